// File: doc/BRIEF.md
# I2C Page-Write Memory Slave

This block is the write side of a serial memory that answers on an I2C bus. It watches the two bus lines through synchronizers and finds START and STOP conditions. It compares the device-select byte with a fixed type code and three strap inputs. It then takes a 12-bit word address split over two bytes. Each data byte after that goes into a 32-entry page buffer, and every byte it accepts is acknowledged by pulling SDA low for the ninth clock.

Nothing reaches the storage array while bytes are still arriving. When the master ends the transfer with STOP, a sequencer copies every filled buffer slot into the array, one slot per clock cycle. A busy flag then stays high for a set number of cycles, and while it is high the device does not acknowledge its address. A write-protect input lets transfers complete with acknowledges but blocks the copy. A registered read port gives direct access to the array contents.

Top module: `i2c_pgwr_eeprom`

## Requirements
- R1: A transfer starts only at a START, which is SDA falling while SCL is high. The device byte `1010` + `dev_sel_i[2:0]` + `0` (R/W = 0 in bit 0, MSB first) is acknowledged: `sda_oe` is high during the ninth SCL pulse.
- R2: A device byte with a wrong type code, wrong select bits or R/W = 1 is not acknowledged. Every later byte up to the next START is then ignored: no acknowledge, no array change, no busy.
- R3: The first address byte sets address bits 11..8 from its bits 3..0, and its bits 7..4 have no effect. The second address byte sets bits 7..0. Both are acknowledged.
- R4: Data bytes arrive MSB first and each one is acknowledged. One data byte followed by STOP changes only the addressed location.
- R5: The array does not change before STOP. The copy begins in the cycle after STOP is detected.
- R6: After each data byte, address bits 4..0 increment modulo 32 while bits 11..5 stay fixed, so a burst wraps inside its 32-byte page.
- R7: If more than 32 data bytes arrive, later bytes replace the earlier bytes held in the same page slots.
- R8: While `wp_i` is high at STOP, bytes are still acknowledged, but the array stays unchanged and `busy_o` stays low.
- R9: A commit holds `busy_o` high for exactly BUSY_CYCLES clock cycles. A device byte received during that time is not acknowledged.
- R10: A repeated START before STOP throws away the pending bytes. A later STOP with no new data changes nothing.
- R11: After reset, `sda_oe` and `busy_o` are low.
- R12: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| wp_i | input | 1 | Write protect; 1 blocks the commit at STOP |
| dev_sel_i | input | 3 | Strap bits compared with device byte bits 3..1 |
| busy_o | output | 1 | High while a commit interval runs |
| rd_addr_i | input | 12 | Array read address |
| rd_data_o | output | 8 | Array read data, one cycle after the address |

## Verification
The assertions assume a well-behaved master. Each SCL phase lasts several system clocks, so a bus edge always clears the synchronizers before the next one. SDA changes only while SCL is low, except at START and STOP. The master never sends STOP while the slave holds SDA low. The bench bit-bangs the bus with ten clock cycles per quarter bit and moves SDA a quarter period away from each SCL edge. It releases SDA in every acknowledge slot, so the only assumption it does not test is a master that breaks these timing rules.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK_SET, ST_ACK_HOLD, ST_IGNORE} bus_st_t;
  typedef enum logic [1:0] {PH_DEV, PH_WAH, PH_WAL, PH_DATA} phase_t;
  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_o     = scl_sh[SYNC_STAGES-1];
  assign sda_o     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_o & ~scl_d;
  assign scl_fall  = ~scl_o & scl_d;
  // bus conditions: SDA moves while SCL stays high across both samples
  assign start_det = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_det  = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot [SLOTS];
  logic [SLOTS-1:0]  filled;

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) filled <= '0;
    else if (wr_en) filled[wr_idx] <= 1'b1;
  end

  assign rd_data  = slot[rd_idx];
  assign rd_valid = filled[rd_idx];

  AST_PB_CLR_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    clr |-> !wr_en); // R6
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2c_pgwr_eeprom.sv
module i2c_pgwr_eeprom
  import eeprom_pw_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              wp_i,
  input  logic [2:0]        dev_sel_i,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int HI_W   = ADDR_W - 8;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_t             state;
  phase_t              phase;
  logic [2:0]          bit_cnt;
  logic [6:0]          shreg;
  logic [ADDR_W-1:0]   wa_q;
  logic                armed;
  logic                commit_act;
  logic [PAGE_W-1:0]   commit_idx;
  logic [BUSY_W-1:0]   busy_cnt;

  logic [7:0] byte_v;
  logic       byte_done, dev_ok, pb_clr, pb_wr, start_commit;
  logic [7:0] pb_rd_data;
  logic       pb_rd_valid;

  assign byte_v       = {shreg, sda_s};
  assign byte_done    = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7);
  assign dev_ok       = (byte_v[7:4] == DEV_TYPE_CODE) && (byte_v[3:1] == dev_sel_i)
                        && !byte_v[0] && !busy_o;
  assign pb_clr       = byte_done && (phase == PH_DEV) && dev_ok;
  assign pb_wr        = byte_done && (phase == PH_DATA);
  assign start_commit = stop_det && armed && !wp_i;
  assign busy_o       = (busy_cnt != '0);

  // bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= PH_DEV;
      bit_cnt <= '0;
      shreg   <= '0;
      wa_q    <= '0;
      armed   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_RX;
      phase   <= PH_DEV;
      bit_cnt <= '0;
      armed   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      armed   <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_RX: if (scl_rise) begin
          shreg   <= byte_v[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            state <= ST_ACK_SET;
            case (phase)
              PH_DEV:  if (!dev_ok) state <= ST_IGNORE;
              PH_WAH:  wa_q[ADDR_W-1:8] <= byte_v[HI_W-1:0];
              PH_WAL:  wa_q[7:0] <= byte_v;
              default: begin
                wa_q[PAGE_W-1:0] <= wa_q[PAGE_W-1:0] + 1'b1;
                armed <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK_SET: if (scl_fall) begin
          sda_oe <= 1'b1;
          state  <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          sda_oe <= 1'b0;
          state  <= ST_RX;
          if (phase != PH_DATA) phase <= phase_t'(phase + 2'd1);
        end
        default: ;
      endcase
    end
  end

  // commit sequencer and busy interval
  always_ff @(posedge clk) begin
    if (rst) begin
      commit_act <= 1'b0;
      commit_idx <= '0;
      busy_cnt   <= '0;
    end else if (start_commit) begin
      commit_act <= 1'b1;
      commit_idx <= '0;
      busy_cnt   <= BUSY_W'(BUSY_CYCLES);
    end else begin
      if (busy_o) busy_cnt <= busy_cnt - 1'b1;
      if (commit_act) begin
        commit_idx <= commit_idx + 1'b1;
        if (commit_idx == '1) commit_act <= 1'b0;
      end
    end
  end

  page_buffer #(.PAGE_W(PAGE_W), .DATA_W(8)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .wr_en(pb_wr),
    .wr_idx(wa_q[PAGE_W-1:0]), .wr_data(byte_v),
    .rd_idx(commit_idx), .rd_data(pb_rd_data), .rd_valid(pb_rd_valid)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(commit_act && pb_rd_valid),
    .waddr({wa_q[ADDR_W-1:PAGE_W], commit_idx}), .wdata(pb_rd_data),
    .raddr(rd_addr_i), .rdata(rd_data_o)
  );

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R12
  AST_IGNORE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe); // R2
  AST_BUSY_NO_DEV_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && phase == PH_DEV) |-> !busy_o); // R9
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_act) |-> $past(stop_det)); // R5
  AST_WP_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_act) |-> !$past(wp_i)); // R8
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && $past(phase) == PH_DATA)
      |-> wa_q[ADDR_W-1:PAGE_W] == $past(wa_q[ADDR_W-1:PAGE_W])); // R6
  AST_BUSY_COVERS_COMMIT: assert property (@(posedge clk) disable iff (rst)
    commit_act |-> busy_o); // R9
endmodule

// File: tb/i2c_pgwr_eeprom_test.sv
module i2c_pgwr_eeprom_test;
  localparam int BUSY = 600;
  localparam int Q    = 10;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
  // vector: {addr hi byte, addr lo byte, data}
  localparam logic [23:0] VEC [7] = '{24'hF0103C, 24'h0122D1, 24'h5123A5,
                                      24'h2FFF0F, 24'hC78077, 24'h030011, 24'h8A55E2};

  logic clk = 0, rst = 1;
  logic scl_m = 1, sda_m = 1, wp = 0;
  logic sda_oe, busy_o;
  logic [11:0] rd_addr = '0;
  logic [7:0]  rd_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0;
  int busy_run = 0, busy_last = 0, oe_viol = 0;
  logic oe_prev = 0;
  logic [7:0] payload [64];

  always #10 clk = ~clk;

  i2c_pgwr_eeprom #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wp_i(wp), .dev_sel_i(SEL), .busy_o(busy_o),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(negedge clk) begin
    if (busy_o) busy_run <= busy_run + 1;
    else if (busy_run != 0) begin busy_last <= busy_run; busy_run <= 0; end
    if (!rst && sda_oe != oe_prev && scl_m) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); ack = sda_oe; wq(); scl_m = 0; wq();
  endtask

  task automatic txn(input logic [7:0] dev, input logic [7:0] wah, input logic [7:0] wal,
                     input int n, input bit do_stop, output int acks);
    logic a;
    acks = 0;
    i2c_start();
    send_byte(dev, a); acks += int'(a);
    send_byte(wah, a); acks += int'(a);
    send_byte(wal, a); acks += int'(a);
    for (int k = 0; k < n; k++) begin send_byte(payload[k], a); acks += int'(a); end
    if (do_stop) i2c_stop();
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    rd_addr = a; repeat (2) @(negedge clk); d = rd_data;
  endtask

  task automatic wait_idle();
    repeat (20) @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    int acks;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 sda_oe after reset", int'(sda_oe), 0);
    chk("R11 busy after reset", int'(busy_o), 0);

    // table walk: single-byte writes (R1, R3, R4)
    for (int i = 0; i < 7; i++) begin
      payload[0] = VEC[i][7:0];
      txn(DEVW, VEC[i][23:16], VEC[i][15:8], 1, 1, acks);
      chk("R1 R3 R4 acks on byte write", acks, 4);
      wait_idle();
      rd({VEC[i][19:16], VEC[i][15:8]}, d);
      chk("R3 R4 readback", int'(d), int'(VEC[i][7:0]));
    end
    rd(12'h122, d);
    chk("R4 neighbour untouched", int'(d), 'hD1);

    // R5: no change before STOP
    payload[0] = 8'h99;
    txn(DEVW, 8'h00, 8'h10, 1, 0, acks);
    rd(12'h010, d);
    chk("R5 old value before STOP", int'(d), 'h3C);
    i2c_stop(); wait_idle();
    rd(12'h010, d);
    chk("R5 new value after STOP", int'(d), 'h99);

    // R2: wrong select bits, and R/W = 1
    payload[0] = 8'h00;
    txn({4'b1010, 3'b000, 1'b0}, 8'h07, 8'h80, 1, 1, acks);
    chk("R2 no ack on select mismatch", acks, 0);
    repeat (20) @(negedge clk);
    chk("R2 no busy after mismatch", int'(busy_o), 0);
    rd(12'h780, d);
    chk("R2 array unchanged", int'(d), 'h77);
    txn({DEVW[7:1], 1'b1}, 8'h07, 8'h80, 1, 1, acks);
    chk("R2 no ack on read command", acks, 0);
    txn(8'h2A, 8'h07, 8'h80, 1, 1, acks);
    chk("R2 no ack on wrong type code", acks, 0);

    // R6: burst wraps within page 0x200
    payload[0] = 8'hEE;
    txn(DEVW, 8'h02, 8'h20, 1, 1, acks); wait_idle();
    for (int k = 0; k < 8; k++) payload[k] = 8'h40 + 8'(k);
    txn(DEVW, 8'h02, 8'h1C, 8, 1, acks);
    chk("R6 burst acks", acks, 11);
    wait_idle();
    for (int k = 0; k < 8; k++) begin
      rd({7'h10, 5'(5'h1C + k)}, d);
      chk("R6 wrapped slot", int'(d), 'h40 + k);
    end
    rd(12'h220, d);
    chk("R6 next page untouched", int'(d), 'hEE);

    // R7: 34 bytes overwrite the first two slots; R9 busy checks
    for (int k = 0; k < 34; k++) payload[k] = 8'h80 + 8'(k);
    txn(DEVW, 8'h03, 8'h40, 34, 1, acks);
    chk("R7 overflow acks", acks, 37);
    chk("R9 busy after commit STOP", int'(busy_o), 1);
    txn(DEVW, 8'h03, 8'h40, 0, 1, acks);
    chk("R9 no ack while busy", acks, 0);
    wait_idle();
    chk("R9 busy length", busy_last, BUSY);
    rd(12'h340, d); chk("R7 slot 0 overwritten", int'(d), 'hA0);
    rd(12'h341, d); chk("R7 slot 1 overwritten", int'(d), 'hA1);
    rd(12'h342, d); chk("R7 slot 2 kept", int'(d), 'h82);
    rd(12'h35F, d); chk("R7 slot 31 kept", int'(d), 'h9F);

    // R8: write protect
    wp = 1;
    payload[0] = 8'h66;
    txn(DEVW, 8'h03, 8'h00, 1, 1, acks);
    chk("R8 acks under protect", acks, 4);
    repeat (10) @(negedge clk);
    chk("R8 no busy under protect", int'(busy_o), 0);
    rd(12'h300, d);
    chk("R8 array unchanged", int'(d), 'h11);
    wp = 0;

    // R10: repeated START discards pending byte
    payload[0] = 8'h00;
    txn(DEVW, 8'h0A, 8'h55, 1, 0, acks);
    chk("R10 acks before repeated START", acks, 4);
    i2c_start(); i2c_stop();
    repeat (10) @(negedge clk);
    chk("R10 no busy", int'(busy_o), 0);
    rd(12'hA55, d);
    chk("R10 array unchanged", int'(d), 'hE2);

    chk("R12 sda_oe moved only with SCL low", oe_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule